// File: doc/BRIEF.md
# BIST Column Failure Recorder

This block sits beside the self-test engine of a data store that is split into four quadrants. The test engine runs its march patterns and, on any cycle where it finds a bad column, it presents one failure event: the quadrant, the bank inside that quadrant, and the column code. The recorder turns that stream into a compact repair record. Each quadrant gets a 34-bit status word that holds up to two failing banks. For each bank the word keeps one bad column in the lower half of the column range and one in the upper half.

A quadrant can run out of room. This happens when a third bank fails, or when a second distinct column fails in a half that already holds a column. The record then cannot describe a repair, so the affected column fields take a reserved fatal code and a single fatal flag, shared by all quadrants, is raised. The fatal code marks which quadrant caused the flag. A start pulse clears the record and opens the recording window. An end pulse closes the window and raises the done indication. Repair logic reads the four words once done is high.

Top module: `bist_colfail_rec`

## Requirements
- R1: After reset, and in the cycle after a start pulse, every status word reads idle: every column field is 0x7F (no failure), every bank field is 0x7, and both the fatal flag and done are low. An event in the same cycle as start is dropped.
- R2: Word layout per quadrant: entry 1 has its bank at [16:14], its high column at [13:7] and its low column at [6:0]. Entry 2 has its bank at [33:31], its high column at [30:24] and its low column at [23:17]. The first distinct failing bank of a quadrant takes entry 1 and the second takes entry 2. An unused entry keeps bank 0x7.
- R3: A column code below 35 is stored in the low field of its bank's entry. A code from 35 to 0x45 is stored in the high field. The other field stays 0x7F.
- R4: A report that repeats a column already stored for that bank and half changes nothing and uses no entry.
- R5: A second, different column in a field that is already filled sets that field to 0x7E and raises the fatal flag.
- R6: A third distinct bank in a quadrant sets all four column fields of that quadrant to 0x7E and raises the fatal flag. The bank fields are kept. Later events for that quadrant are ignored.
- R7: The fatal flag is shared and stays high until the next start. Quadrants that have not overflowed keep recording while it is high.
- R8: Column codes above 0x45 are ignored.
- R9: Events are accepted only between a start and an end pulse. An event in the same cycle as end is still accepted. Done goes high in the cycle after end and stays high until the next start. While done is high, events change nothing.
- R10: An event for one quadrant never changes another quadrant's word.
- R11: An accepted event appears in the status word after the one clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Clear the record and open the recording window |
| end_i | input | 1 | Close the recording window |
| ev_valid_i | input | 1 | Failure event present this cycle |
| ev_quad_i | input | 2 | Quadrant of the failure |
| ev_bank_i | input | 3 | Bank of the failure |
| ev_col_i | input | 7 | Column code of the failure |
| status_o | output | 136 | Four 34-bit status words; quadrant q at [q*34 +: 34] |
| fatal_o | output | 1 | Shared fatal flag |
| done_o | output | 1 | Recording window closed |

## Verification
The hardest states to reach are the saturated ones. In the first, a quadrant has overflowed, the fatal flag is already set, and further events still arrive, both for that quadrant and for its neighbours. In the second, a conflict code sits in a field that then receives yet another column. The bench builds these states on purpose. It fills a quadrant with two banks, adds a third to overflow it, and then sends repeats and fresh banks to that quadrant and to a clean quadrant. It also drives the start/event and end/event collisions in the same cycle.

// File: rtl/bcr_pkg.sv
// Shared defaults and types for the BIST column failure recorder.
// Assumes: all modules take their widths as parameters defaulted from here.
package bcr_pkg;
    localparam int DEF_NUM_QUAD  = 4;
    localparam int DEF_BANK_W    = 3;
    localparam int DEF_COL_W     = 7;
    localparam int DEF_COL_LAST  = 'h45;
    localparam int DEF_COL_SPLIT = 35;

    // Recording window state
    typedef enum logic [1:0] {
        RUN_IDLE   = 2'd0,
        RUN_ACTIVE = 2'd1,
        RUN_DONE   = 2'd2
    } run_e;
endpackage

// File: rtl/bcr_run_ctrl.sv
// Recording window control.
// Opens the window on start and closes it on end. It tells the datapath
// when events are accepted and when the record must be cleared.
// Assumes: start has priority over end and over any event in the same cycle.
module bcr_run_ctrl
    import bcr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic end_i,
    output logic accept_o,
    output logic clear_o,
    output logic done_o
);
    run_e state_q, state_d;

    // Next window state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = RUN_ACTIVE;
        end else if (end_i && state_q == RUN_ACTIVE) begin
            state_d = RUN_DONE;
        end
    end

    // Window state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= RUN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign accept_o = (state_q == RUN_ACTIVE) && !start_i;
    assign clear_o  = start_i;
    assign done_o   = (state_q == RUN_DONE);
endmodule

// File: rtl/bcr_ev_decode.sv
// Failure event decoder.
// Drops column codes outside the legal range, picks the column half, and
// steers the event to exactly one quadrant recorder.
// Assumes: at most one event per cycle.
module bcr_ev_decode #(
    parameter  int NUM_QUAD  = bcr_pkg::DEF_NUM_QUAD,
    parameter  int COL_W     = bcr_pkg::DEF_COL_W,
    parameter  int COL_LAST  = bcr_pkg::DEF_COL_LAST,
    parameter  int COL_SPLIT = bcr_pkg::DEF_COL_SPLIT,
    localparam int QUAD_W    = (NUM_QUAD > 1) ? $clog2(NUM_QUAD) : 1
) (
    input  logic                accept_i,
    input  logic                valid_i,
    input  logic [QUAD_W-1:0]   quad_i,
    input  logic [COL_W-1:0]    col_i,
    output logic [NUM_QUAD-1:0] quad_ev_o,
    output logic                high_o
);
    localparam logic [COL_W-1:0] LAST_C  = COL_W'(COL_LAST);
    localparam logic [COL_W-1:0] SPLIT_C = COL_W'(COL_SPLIT);

    logic legal;

    // Event qualifies only inside the window and with a legal column code
    assign legal  = accept_i && valid_i && (col_i <= LAST_C);
    assign high_o = (col_i >= SPLIT_C);

    // One enable per quadrant recorder
    for (genvar q = 0; q < NUM_QUAD; q++) begin : g_sel
        assign quad_ev_o[q] = legal && (quad_i == QUAD_W'(q));
    end
endmodule

// File: rtl/bcr_quad_rec.sv
// Per-quadrant failure record.
// Holds two bank entries. Each entry keeps one bad column in the low half
// and one in the high half. It merges repeats, turns conflicts into the fatal
// code, and saturates the whole quadrant on a third bank.
// Assumes: the column input is already range-checked by the decoder.
module bcr_quad_rec #(
    parameter  int BANK_W  = bcr_pkg::DEF_BANK_W,
    parameter  int COL_W   = bcr_pkg::DEF_COL_W,
    localparam int ENTRY_W = BANK_W + 2 * COL_W,
    localparam int WORD_W  = 2 * ENTRY_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              ev_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              high_i,
    output logic [WORD_W-1:0] word_o,
    output logic              fatal_o
);
    localparam logic [COL_W-1:0]  COL_NONE  = '1;
    localparam logic [COL_W-1:0]  COL_FATAL = {{(COL_W-1){1'b1}}, 1'b0};
    localparam logic [BANK_W-1:0] BANK_IDLE = '1;

    logic [1:0]        used_q, used_d;
    logic [BANK_W-1:0] bank_q [2];
    logic [BANK_W-1:0] bank_d [2];
    logic [COL_W-1:0]  hi_q   [2];
    logic [COL_W-1:0]  hi_d   [2];
    logic [COL_W-1:0]  lo_q   [2];
    logic [COL_W-1:0]  lo_d   [2];
    logic              ovf_q, ovf_d;
    logic              fat;
    logic [1:0]        hit;
    logic              have_tgt;
    logic              tgt;
    logic              saturate;
    logic [COL_W-1:0]  cur;

    // Bank match against entries already in use
    always_comb begin
        for (int e = 0; e < 2; e++) begin
            hit[e] = used_q[e] && (bank_q[e] == bank_i);
        end
    end

    // Choose the target entry, or flag overflow when both entries hold other banks
    always_comb begin
        have_tgt = 1'b1;
        saturate = 1'b0;
        tgt      = 1'b0;
        if (hit[0]) begin
            tgt = 1'b0;
        end else if (hit[1]) begin
            tgt = 1'b1;
        end else if (!used_q[0]) begin
            tgt = 1'b0;
        end else if (!used_q[1]) begin
            tgt = 1'b1;
        end else begin
            have_tgt = 1'b0;
            saturate = 1'b1;
        end
    end

    // Current content of the field the event lands in
    assign cur = high_i ? hi_q[tgt] : lo_q[tgt];

    // Next record state
    always_comb begin
        used_d = used_q;
        bank_d = bank_q;
        hi_d   = hi_q;
        lo_d   = lo_q;
        ovf_d  = ovf_q;
        fat    = 1'b0;
        if (clr_i) begin
            used_d = '0;
            ovf_d  = 1'b0;
            for (int e = 0; e < 2; e++) begin
                bank_d[e] = BANK_IDLE;
                hi_d[e]   = COL_NONE;
                lo_d[e]   = COL_NONE;
            end
        end else if (ev_i && !ovf_q) begin
            if (have_tgt) begin
                used_d[tgt] = 1'b1;
                bank_d[tgt] = bank_i;
                if (cur == COL_NONE) begin
                    if (high_i) hi_d[tgt] = col_i;
                    else        lo_d[tgt] = col_i;
                end else if (cur != col_i) begin
                    fat = 1'b1;
                    if (high_i) hi_d[tgt] = COL_FATAL;
                    else        lo_d[tgt] = COL_FATAL;
                end
            end else if (saturate) begin
                ovf_d = 1'b1;
                fat   = 1'b1;
                for (int e = 0; e < 2; e++) begin
                    hi_d[e] = COL_FATAL;
                    lo_d[e] = COL_FATAL;
                end
            end
        end
    end

    // Record registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            used_q <= '0;
            ovf_q  <= 1'b0;
            for (int e = 0; e < 2; e++) begin
                bank_q[e] <= BANK_IDLE;
                hi_q[e]   <= COL_NONE;
                lo_q[e]   <= COL_NONE;
            end
        end else begin
            used_q <= used_d;
            ovf_q  <= ovf_d;
            bank_q <= bank_d;
            hi_q   <= hi_d;
            lo_q   <= lo_d;
        end
    end

    assign word_o  = {bank_q[1], hi_q[1], lo_q[1], bank_q[0], hi_q[0], lo_q[0]};
    assign fatal_o = fat;
endmodule

// File: rtl/bist_colfail_rec.sv
// BIST column failure recorder, top level.
// Puts the window control, the event decoder and one recorder per
// quadrant together, and keeps the shared fatal flag.
// Assumes: one failure event per cycle at most.
module bist_colfail_rec #(
    parameter  int NUM_QUAD  = bcr_pkg::DEF_NUM_QUAD,
    parameter  int BANK_W    = bcr_pkg::DEF_BANK_W,
    parameter  int COL_W     = bcr_pkg::DEF_COL_W,
    parameter  int COL_LAST  = bcr_pkg::DEF_COL_LAST,
    parameter  int COL_SPLIT = bcr_pkg::DEF_COL_SPLIT,
    localparam int QUAD_W    = (NUM_QUAD > 1) ? $clog2(NUM_QUAD) : 1,
    localparam int WORD_W    = 2 * (BANK_W + 2 * COL_W)
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       start_i,
    input  logic                       end_i,
    input  logic                       ev_valid_i,
    input  logic [QUAD_W-1:0]          ev_quad_i,
    input  logic [BANK_W-1:0]          ev_bank_i,
    input  logic [COL_W-1:0]           ev_col_i,
    output logic [NUM_QUAD*WORD_W-1:0] status_o,
    output logic                       fatal_o,
    output logic                       done_o
);
    logic                accept;
    logic                clear;
    logic                high;
    logic [NUM_QUAD-1:0] quad_ev;
    logic [NUM_QUAD-1:0] quad_fat;
    logic                fatal_q;

    bcr_run_ctrl u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .end_i    (end_i),
        .accept_o (accept),
        .clear_o  (clear),
        .done_o   (done_o)
    );

    bcr_ev_decode #(
        .NUM_QUAD  (NUM_QUAD),
        .COL_W     (COL_W),
        .COL_LAST  (COL_LAST),
        .COL_SPLIT (COL_SPLIT)
    ) u_dec (
        .accept_i  (accept),
        .valid_i   (ev_valid_i),
        .quad_i    (ev_quad_i),
        .col_i     (ev_col_i),
        .quad_ev_o (quad_ev),
        .high_o    (high)
    );

    for (genvar q = 0; q < NUM_QUAD; q++) begin : g_quad
        bcr_quad_rec #(
            .BANK_W (BANK_W),
            .COL_W  (COL_W)
        ) u_rec (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (clear),
            .ev_i    (quad_ev[q]),
            .bank_i  (ev_bank_i),
            .col_i   (ev_col_i),
            .high_i  (high),
            .word_o  (status_o[q*WORD_W +: WORD_W]),
            .fatal_o (quad_fat[q])
        );
    end

    // Shared sticky fatal flag, cleared only by reset or start
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fatal_q <= 1'b0;
        end else if (clear) begin
            fatal_q <= 1'b0;
        end else if (|quad_fat) begin
            fatal_q <= 1'b1;
        end
    end

    assign fatal_o = fatal_q;
endmodule

// File: rtl/bist_colfail_chk.sv
// Property checker for the BIST column failure recorder, bound to the top.
// Assumes: it sees only the ports of the top module.
module bist_colfail_chk #(
    parameter  int NUM_QUAD = 4,
    parameter  int BANK_W   = 3,
    parameter  int COL_W    = 7,
    parameter  int COL_LAST = 'h45,
    localparam int QUAD_W   = (NUM_QUAD > 1) ? $clog2(NUM_QUAD) : 1,
    localparam int ENTRY_W  = BANK_W + 2 * COL_W,
    localparam int WORD_W   = 2 * ENTRY_W
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       start_i,
    input logic                       ev_valid_i,
    input logic [QUAD_W-1:0]          ev_quad_i,
    input logic [COL_W-1:0]           ev_col_i,
    input logic [NUM_QUAD*WORD_W-1:0] status_o,
    input logic                       fatal_o,
    input logic                       done_o
);
    localparam logic [COL_W-1:0]  C_NONE  = '1;
    localparam logic [COL_W-1:0]  C_FATAL = {{(COL_W-1){1'b1}}, 1'b0};
    localparam logic [COL_W-1:0]  C_LAST  = COL_W'(COL_LAST);
    localparam logic [BANK_W-1:0] B_IDLE  = '1;
    localparam logic [WORD_W-1:0] W_IDLE  = {2{B_IDLE, C_NONE, C_NONE}};

    logic all_idle;
    logic any_fatal_code;

    // Summaries over every column field
    always_comb begin
        all_idle       = 1'b1;
        any_fatal_code = 1'b0;
        for (int q = 0; q < NUM_QUAD; q++) begin
            if (status_o[q*WORD_W +: WORD_W] != W_IDLE) all_idle = 1'b0;
            for (int f = 0; f < 4; f++) begin
                if (status_o[q*WORD_W + (f/2)*ENTRY_W + (f%2)*COL_W +: COL_W] == C_FATAL)
                    any_fatal_code = 1'b1;
            end
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (all_idle && !fatal_o && !done_o)); // R1

    AST_FATAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fatal_o && !start_i) |=> fatal_o); // R7

    AST_FATAL_HAS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fatal_o) |-> any_fatal_code); // R5

    AST_BAD_COL_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_valid_i && (ev_col_i > C_LAST) && !start_i) |=> ($stable(status_o) && $stable(fatal_o))); // R8

    AST_DONE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> ($stable(status_o) && done_o)); // R9

    for (genvar q = 0; q < NUM_QUAD; q++) begin : g_q
        AST_QUAD_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!start_i && !(ev_valid_i && ev_quad_i == QUAD_W'(q)))
            |=> $stable(status_o[q*WORD_W +: WORD_W])); // R10
        for (genvar f = 0; f < 4; f++) begin : g_f
            AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (status_o[q*WORD_W + (f/2)*ENTRY_W + (f%2)*COL_W +: COL_W] <= C_LAST) ||
                (status_o[q*WORD_W + (f/2)*ENTRY_W + (f%2)*COL_W +: COL_W] >= C_FATAL)); // R8
        end
    end
endmodule

bind bist_colfail_rec bist_colfail_chk #(
    .NUM_QUAD (NUM_QUAD),
    .BANK_W   (BANK_W),
    .COL_W    (COL_W),
    .COL_LAST (COL_LAST)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ev_valid_i (ev_valid_i),
    .ev_quad_i  (ev_quad_i),
    .ev_col_i   (ev_col_i),
    .status_o   (status_o),
    .fatal_o    (fatal_o),
    .done_o     (done_o)
);

// File: tb/sim_bist_colfail_rec.sv
`timescale 1ns/1ps
// Directed bench for the BIST column failure recorder.
module sim_bist_colfail_rec;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         endp = 1'b0;
    logic         ev_valid = 1'b0;
    logic [1:0]   ev_quad = '0;
    logic [2:0]   ev_bank = '0;
    logic [6:0]   ev_col = '0;
    logic [135:0] status;
    logic         fatal;
    logic         done;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [33:0] IDLE = {3'h7, 7'h7F, 7'h7F, 3'h7, 7'h7F, 7'h7F};

    always #4 clk = ~clk;

    bist_colfail_rec u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .end_i(endp),
        .ev_valid_i(ev_valid), .ev_quad_i(ev_quad), .ev_bank_i(ev_bank),
        .ev_col_i(ev_col), .status_o(status), .fatal_o(fatal), .done_o(done)
    );

    function automatic logic [33:0] wd(input logic [2:0] b1, input logic [6:0] h1, input logic [6:0] l1,
                                       input logic [2:0] b2, input logic [6:0] h2, input logic [6:0] l2);
        return {b2, h2, l2, b1, h1, l1};
    endfunction

    task automatic chk_word(input int q, input logic [33:0] exp, input string req);
        logic [33:0] act;
        act = status[q*34 +: 34];
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s quad %0d word act=%h exp=%h", req, q, act, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
        end
    endtask

    task automatic start_run();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic ev(input int q, input int b, input int c);
        @(negedge clk);
        ev_valid = 1'b1; ev_quad = 2'(q); ev_bank = 3'(b); ev_col = 7'(c);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        for (int q = 0; q < 4; q++) chk_word(q, IDLE, "R1");
        chk_bit(fatal, 1'b0, "R1", "fatal");
        chk_bit(done, 1'b0, "R1", "done");
    endtask

    // R9: events before the first start are ignored
    task automatic t_before_start();
        ev(0, 1, 3);
        chk_word(0, IDLE, "R9");
    endtask

    // R2 R3 R11: entry placement, half selection, latency
    task automatic t_basic();
        start_run();
        @(negedge clk);
        ev_valid = 1'b1; ev_quad = 2'd0; ev_bank = 3'd2; ev_col = 7'd5;
        #1 chk_word(0, IDLE, "R11");
        @(negedge clk); ev_valid = 1'b0;
        chk_word(0, wd(2, 7'h7F, 7'h05, 7, 7'h7F, 7'h7F), "R11");
        ev(0, 2, 40);
        chk_word(0, wd(2, 7'h28, 7'h05, 7, 7'h7F, 7'h7F), "R3");
        ev(0, 5, 'h45);
        chk_word(0, wd(2, 7'h28, 7'h05, 5, 7'h45, 7'h7F), "R2");
        ev(1, 0, 34);
        ev(1, 0, 35);
        chk_word(1, wd(0, 7'h23, 7'h22, 7, 7'h7F, 7'h7F), "R3");
        chk_bit(fatal, 1'b0, "R2", "fatal");
    endtask

    // R4: repeated reports
    task automatic t_repeat();
        start_run();
        ev(1, 3, 10);
        ev(1, 3, 10);
        chk_word(1, wd(3, 7'h7F, 7'h0A, 7, 7'h7F, 7'h7F), "R4");
        ev(1, 3, 50);
        ev(1, 3, 50);
        chk_word(1, wd(3, 7'h32, 7'h0A, 7, 7'h7F, 7'h7F), "R4");
        chk_bit(fatal, 1'b0, "R4", "fatal");
    endtask

    // R5 R7: conflict in a field, other quadrants keep recording
    task automatic t_conflict();
        start_run();
        ev(2, 1, 4);
        ev(2, 1, 6);
        chk_word(2, wd(1, 7'h7F, 7'h7E, 7, 7'h7F, 7'h7F), "R5");
        chk_bit(fatal, 1'b1, "R5", "fatal");
        ev(3, 0, 36);
        chk_word(3, wd(0, 7'h24, 7'h7F, 7, 7'h7F, 7'h7F), "R7");
        ev(2, 1, 4);
        chk_word(2, wd(1, 7'h7F, 7'h7E, 7, 7'h7F, 7'h7F), "R5");
        chk_bit(fatal, 1'b1, "R7", "fatal sticky");
    endtask

    // R6 R10: third bank saturates the quadrant
    task automatic t_overflow();
        start_run();
        chk_bit(fatal, 1'b0, "R1", "fatal after start");
        ev(3, 0, 1);
        ev(3, 1, 2);
        chk_word(3, wd(0, 7'h7F, 7'h01, 1, 7'h7F, 7'h02), "R2");
        ev(3, 2, 3);
        chk_word(3, wd(0, 7'h7E, 7'h7E, 1, 7'h7E, 7'h7E), "R6");
        chk_bit(fatal, 1'b1, "R6", "fatal");
        ev(3, 0, 1);
        ev(3, 4, 40);
        chk_word(3, wd(0, 7'h7E, 7'h7E, 1, 7'h7E, 7'h7E), "R6");
        chk_word(0, IDLE, "R10");
        ev(0, 6, 7);
        chk_word(0, wd(6, 7'h7F, 7'h07, 7, 7'h7F, 7'h7F), "R7");
        chk_word(3, wd(0, 7'h7E, 7'h7E, 1, 7'h7E, 7'h7E), "R10");
    endtask

    // R8: out-of-range column codes
    task automatic t_badcol();
        start_run();
        ev(0, 0, 'h46);
        ev(0, 0, 'h7F);
        ev(0, 0, 'h7E);
        chk_word(0, IDLE, "R8");
        chk_bit(fatal, 1'b0, "R8", "fatal");
    endtask

    // R9 R1: end window, done, start collision
    task automatic t_window();
        start_run();
        @(negedge clk);
        ev_valid = 1'b1; ev_quad = 2'd1; ev_bank = 3'd4; ev_col = 7'd0; endp = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0; endp = 1'b0;
        chk_bit(done, 1'b1, "R9", "done");
        chk_word(1, wd(4, 7'h7F, 7'h00, 7, 7'h7F, 7'h7F), "R9");
        ev(1, 4, 60);
        ev(2, 0, 9);
        chk_word(1, wd(4, 7'h7F, 7'h00, 7, 7'h7F, 7'h7F), "R9");
        chk_word(2, IDLE, "R9");
        @(negedge clk);
        start = 1'b1; ev_valid = 1'b1; ev_quad = 2'd2; ev_bank = 3'd1; ev_col = 7'd8;
        @(negedge clk);
        start = 1'b0; ev_valid = 1'b0;
        chk_word(1, IDLE, "R1");
        chk_word(2, IDLE, "R1");
        chk_bit(done, 1'b0, "R1", "done cleared");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_before_start();
        t_basic();
        t_repeat();
        t_conflict();
        t_overflow();
        t_badcol();
        t_window();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule